// File: doc/BRIEF.md
# Power-Management Bus Command Sequencer

This block is the bus-owning master of a two-wire power-management bus. It drives the clock line and the output side of a shared data line. Each request it accepts becomes one complete command sequence on the bus. A sequence opens with a start pulse on the data line while the clock stays low. A 13-bit command frame follows, carrying the 4-bit target address, the 8-bit command code and a parity bit. Next come one or more 9-bit data frames, then a single acknowledge bit, and finally a park bit that hands the line back to the pull-up.

The data line is split into an output value, an output enable and a sampled input, so the open bus stays outside the block. For a write, the master shifts out the request's bytes. For a read, the master releases the line during the data frames and captures what the addressed device returns. It also checks the parity of each returned frame. A one-cycle completion pulse reports the acknowledge level and the parity result. The clock period is set by a parameter as a multiple of the system clock.

Top module: `pwr_cmd_master`

## Requirements
- R1: After reset, and whenever no sequence is in progress, `sclk` is low, `sdaOe` is low, `sdaOut` is low, `reqReady` is high and `done` is low. Whenever `sdaOe` is low, `sdaOut` is low.
- R2: A sequence begins with two bit periods of 2*HALF_DIV system clocks each. During both, `sclk` stays low and `sdaOe` is high. `sdaOut` is 1 in the first period and 0 in the second.
- R3: The command frame follows as 13 driven bits: the address (4 bits), then the command code (8 bits), both most significant bit first. The last bit is an odd parity bit, which makes the count of ones across all 13 bits odd.
- R4: Every bit after the start pulse lasts 2*HALF_DIV system clocks. `sclk` is high for the first HALF_DIV clocks and low for the rest. `sdaOut` and `sdaOe` change only at the start of a bit, never while `sclk` is high or at its falling edge.
- R5: On a write (`reqRead`=0), the master drives each data frame as 8 bits, most significant bit first, followed by an odd parity bit. Byte k is taken from `reqData[8k+7:8k]`, and byte 0 is sent first.
- R6: The number of data frames is `reqLen`, with two exceptions: a value of 0 sends one frame, and a value above MAX_BYTES sends MAX_BYTES frames.
- R7: On a read (`reqRead`=1), the master keeps `sdaOe` low for all 9 bits of every data frame. It samples `sdaIn` at each falling edge of `sclk` and places byte k into `rspData[8k+7:8k]`. Bytes not read, and all bytes after a write, read as 0.
- R8: `rspParErr` is 1 after a read if any returned 9-bit frame held an even number of ones. It is always 0 after a write.
- R9: After the last data frame comes one acknowledge bit. During it `sdaOe` is low and the clock pulses as in R4. `rspAck` takes the `sdaIn` level sampled at the falling edge, where 1 means acknowledged and 0 means not acknowledged.
- R10: The last bit is a park bit: `sdaOe` high, `sdaOut` 0 and one `sclk` pulse. After it the line is released and the clock stays low.
- R11: A request is accepted on a clock edge where `reqValid` and `reqReady` are both high. From the next cycle, `reqReady` stays low until the cycle in which `done` pulses for exactly one cycle. `reqReady` is high again in that same cycle. `rspData`, `rspAck` and `rspParErr` keep their values until the next request is accepted.
- R12: The request inputs are captured when a request is accepted. Changing them during a sequence has no effect. `sdaIn` is ignored outside read data frames and the acknowledge bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer idle and able to accept |
| reqRead | input | 1 | 1 = read data frames from the device, 0 = write |
| reqAddr | input | 4 | Target device address |
| reqCmd | input | 8 | Command code |
| reqLen | input | $clog2(MAX_BYTES+1) | Number of data frames (clamped per R6) |
| reqData | input | 8*MAX_BYTES | Write bytes, byte 0 in the low bits |
| sclk | output | 1 | Bus clock |
| sdaOut | output | 1 | Data line value while driven |
| sdaOe | output | 1 | Data line driver enable |
| sdaIn | input | 1 | Sampled data line level |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| rspAck | output | 1 | Acknowledge level of the last sequence |
| rspParErr | output | 1 | Parity error in a returned read frame |
| rspData | output | 8*MAX_BYTES | Bytes captured by the last read |

## Verification
A wrong state or bit counter shows at the pins within one bit period. A frame comes out a bit too long or too short, or a clock pulse appears during the start pulse. Every later bit is then shifted, so comparing `sclk`, `sdaOe` and `sdaOut` against an independently built waveform on every clock catches it at once. A corrupted byte index or capture position shows up only in `rspData` at the completion pulse, so the bench reads back several byte patterns and lengths. It also includes frames with deliberately bad parity, to tie each returned byte and parity result to its own frame.

// File: rtl/pwr_cmd_pkg.sv
package pwr_cmd_pkg;

  // Kind of bit slot currently on the bus; also the control state.
  typedef enum logic [2:0] {
    K_IDLE,
    K_START,
    K_CMD,
    K_DATA,
    K_ACK,
    K_PARK
  } slotKind_t;

  localparam int START_LAST = 1;   // two start periods
  localparam int CMD_LAST   = 12;  // 13-bit command frame
  localparam int DATA_LAST  = 8;   // 9-bit data frame

  // Strobes from control to datapath.
  typedef struct packed {
    logic       load;      // request accepted this edge
    logic       sample;    // falling sclk edge in a receive slot
    logic       finish;    // last cycle of the park bit
    logic       sclkHigh;  // clock level for this cycle
    slotKind_t  kind;      // slot kind being produced
    logic [3:0] bitIdx;    // bit position inside the frame
  } seqStrobe_t;

endpackage

// File: rtl/pcm_ctrl.sv
module pcm_ctrl
  import pwr_cmd_pkg::*;
#(
  parameter int HALF_DIV  = 2,
  parameter int MAX_BYTES = 4
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                reqValid,
  input  logic [$clog2(MAX_BYTES+1)-1:0]      reqLen,
  output logic                                reqReady,
  output seqStrobe_t                          strobe,
  output logic [((MAX_BYTES>1)?$clog2(MAX_BYTES):1)-1:0] byteIdx
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int LEN_W = $clog2(MAX_BYTES + 1);
  localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

  slotKind_t        state;
  logic [DIV_W-1:0] divCnt;
  logic             half;      // 0 = first half of bit, 1 = second
  logic [3:0]       bitIdx;
  logic [IDX_W-1:0] lastByte;
  logic [IDX_W-1:0] lenClamp;
  logic             tickEnd;
  logic             slotEnd;
  logic             accept;

  assign tickEnd  = (divCnt == DIV_W'(HALF_DIV - 1));
  assign slotEnd  = tickEnd && half;
  assign accept   = (state == K_IDLE) && reqValid;
  assign reqReady = (state == K_IDLE);

  // Frame count: zero means one, anything above the buffer is capped.
  always_comb begin
    if (reqLen == '0)
      lenClamp = '0;
    else if (int'(reqLen) > MAX_BYTES)
      lenClamp = IDX_W'(MAX_BYTES - 1);
    else
      lenClamp = IDX_W'(int'(reqLen) - 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= K_IDLE;
      divCnt   <= '0;
      half     <= 1'b0;
      bitIdx   <= '0;
      byteIdx  <= '0;
      lastByte <= '0;
    end else if (accept) begin
      state    <= K_START;
      divCnt   <= '0;
      half     <= 1'b0;
      bitIdx   <= '0;
      byteIdx  <= '0;
      lastByte <= lenClamp;
    end else if (state != K_IDLE) begin
      divCnt <= tickEnd ? '0 : divCnt + 1'b1;
      if (tickEnd) half <= ~half;
      if (slotEnd) begin
        unique case (state)
          K_START: begin
            if (bitIdx == 4'(START_LAST)) begin
              state  <= K_CMD;
              bitIdx <= '0;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end
          K_CMD: begin
            if (bitIdx == 4'(CMD_LAST)) begin
              state  <= K_DATA;
              bitIdx <= '0;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end
          K_DATA: begin
            if (bitIdx == 4'(DATA_LAST)) begin
              bitIdx <= '0;
              if (byteIdx == lastByte) state <= K_ACK;
              else                     byteIdx <= byteIdx + 1'b1;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end
          K_ACK:   state <= K_PARK;
          K_PARK:  state <= K_IDLE;
          default: state <= K_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    strobe.load     = accept;
    strobe.sample   = ((state == K_DATA) || (state == K_ACK)) && !half && tickEnd;
    strobe.finish   = (state == K_PARK) && slotEnd;
    strobe.sclkHigh = ((state == K_CMD) || (state == K_DATA) ||
                       (state == K_ACK) || (state == K_PARK)) && !half;
    strobe.kind     = state;
    strobe.bitIdx   = bitIdx;
  end

endmodule

// File: rtl/pcm_datapath.sv
module pcm_datapath
  import pwr_cmd_pkg::*;
#(
  parameter int MAX_BYTES = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  seqStrobe_t               strobe,
  input  logic [((MAX_BYTES>1)?$clog2(MAX_BYTES):1)-1:0] byteIdx,
  input  logic                     reqRead,
  input  logic [3:0]               reqAddr,
  input  logic [7:0]               reqCmd,
  input  logic [8*MAX_BYTES-1:0]   reqData,
  input  logic                     sdaIn,
  output logic                     sclk,
  output logic                     sdaOut,
  output logic                     sdaOe,
  output logic                     done,
  output logic                     rspAck,
  output logic                     rspParErr,
  output logic [8*MAX_BYTES-1:0]   rspData
);

  localparam int BUF_BITS = 8 * MAX_BYTES;
  localparam int BIT_W    = $clog2(BUF_BITS);

  logic                rdR;
  logic [3:0]          addrR;
  logic [7:0]          cmdR;
  logic [BUF_BITS-1:0] txBuf;
  logic                rxPar;
  logic [12:0]         cmdWord;
  logic [7:0]          txByte;
  logic [8:0]          dataWord;
  logic [BIT_W-1:0]    rxIdx;
  logic                nxtOe;
  logic                nxtOut;

  // Odd parity: parity bit makes the total count of ones odd.
  assign cmdWord  = {addrR, cmdR, ~^{addrR, cmdR}};
  assign txByte   = txBuf[{byteIdx, 3'b000} +: 8];
  assign dataWord = {txByte, ~^txByte};

  always_comb rxIdx = BIT_W'(int'(byteIdx) * 8 + 7 - int'(strobe.bitIdx));

  always_comb begin
    nxtOe  = 1'b0;
    nxtOut = 1'b0;
    unique case (strobe.kind)
      K_START: begin
        nxtOe  = 1'b1;
        nxtOut = (strobe.bitIdx == 4'd0);
      end
      K_CMD: begin
        nxtOe  = 1'b1;
        nxtOut = cmdWord[4'(CMD_LAST) - strobe.bitIdx];
      end
      K_DATA: begin
        nxtOe  = !rdR;
        nxtOut = !rdR && dataWord[4'(DATA_LAST) - strobe.bitIdx];
      end
      K_PARK: begin
        nxtOe  = 1'b1;
        nxtOut = 1'b0;
      end
      default: begin
        nxtOe  = 1'b0;
        nxtOut = 1'b0;
      end
    endcase
  end

  // Registered pin drivers and completion pulse.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclk   <= 1'b0;
      sdaOe  <= 1'b0;
      sdaOut <= 1'b0;
      done   <= 1'b0;
    end else begin
      sclk   <= strobe.sclkHigh;
      sdaOe  <= nxtOe;
      sdaOut <= nxtOut;
      done   <= strobe.finish;
    end
  end

  // Request capture and receive path.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdR       <= 1'b0;
      addrR     <= '0;
      cmdR      <= '0;
      txBuf     <= '0;
      rxPar     <= 1'b0;
      rspData   <= '0;
      rspAck    <= 1'b0;
      rspParErr <= 1'b0;
    end else if (strobe.load) begin
      rdR       <= reqRead;
      addrR     <= reqAddr;
      cmdR      <= reqCmd;
      txBuf     <= reqData;
      rxPar     <= 1'b0;
      rspData   <= '0;
      rspAck    <= 1'b0;
      rspParErr <= 1'b0;
    end else if (strobe.sample) begin
      if (strobe.kind == K_ACK) begin
        rspAck <= sdaIn;
      end else if (rdR) begin
        if (strobe.bitIdx == 4'd0) rxPar <= sdaIn;
        else                       rxPar <= rxPar ^ sdaIn;
        if (strobe.bitIdx < 4'(DATA_LAST)) rspData[rxIdx] <= sdaIn;
        else if (!(rxPar ^ sdaIn))         rspParErr <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwr_cmd_master.sv
module pwr_cmd_master
  import pwr_cmd_pkg::*;
#(
  parameter int HALF_DIV  = 2,
  parameter int MAX_BYTES = 4
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               reqValid,
  output logic                               reqReady,
  input  logic                               reqRead,
  input  logic [3:0]                         reqAddr,
  input  logic [7:0]                         reqCmd,
  input  logic [$clog2(MAX_BYTES+1)-1:0]     reqLen,
  input  logic [8*MAX_BYTES-1:0]             reqData,
  output logic                               sclk,
  output logic                               sdaOut,
  output logic                               sdaOe,
  input  logic                               sdaIn,
  output logic                               done,
  output logic                               rspAck,
  output logic                               rspParErr,
  output logic [8*MAX_BYTES-1:0]             rspData
);

  localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

  seqStrobe_t       strobe;
  logic [IDX_W-1:0] byteIdx;

  pcm_ctrl #(.HALF_DIV(HALF_DIV), .MAX_BYTES(MAX_BYTES)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqLen   (reqLen),
    .reqReady (reqReady),
    .strobe   (strobe),
    .byteIdx  (byteIdx)
  );

  pcm_datapath #(.MAX_BYTES(MAX_BYTES)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .byteIdx   (byteIdx),
    .reqRead   (reqRead),
    .reqAddr   (reqAddr),
    .reqCmd    (reqCmd),
    .reqData   (reqData),
    .sdaIn     (sdaIn),
    .sclk      (sclk),
    .sdaOut    (sdaOut),
    .sdaOe     (sdaOe),
    .done      (done),
    .rspAck    (rspAck),
    .rspParErr (rspParErr),
    .rspData   (rspData)
  );

endmodule

// File: rtl/pwr_cmd_master_chk.sv
module pwr_cmd_master_chk (
  input logic clk,
  input logic rstN,
  input logic reqReady,
  input logic sclk,
  input logic sdaOut,
  input logic sdaOe,
  input logic done
);

  // R1: two idle cycles in a row leave the bus quiet.
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    reqReady && $past(reqReady) |-> !sclk && !sdaOe);

  // R1: a released line never shows a driven one.
  a_r1_released_low: assert property (@(posedge clk) disable iff (!rstN)
    !sdaOe |-> !sdaOut);

  // R4: data and enable hold while the clock is high and across its fall.
  a_r4_stable_on_high: assert property (@(posedge clk) disable iff (!rstN)
    $past(sclk) |-> $stable(sdaOut) && $stable(sdaOe));

  // R2: taking the line with the clock low opens with a high start level.
  a_r2_start_high: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) && !sclk |-> sdaOut);

  // R10: taking the line with the clock high is the park bit, driven low.
  a_r10_park_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) && sclk |-> !sdaOut);

  // R11: completion is a single-cycle pulse that coincides with readiness.
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r11_ready_at_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> reqReady);

endmodule

bind pwr_cmd_master pwr_cmd_master_chk i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .sclk     (sclk),
  .sdaOut   (sdaOut),
  .sdaOe    (sdaOe),
  .done     (done)
);

// File: tb/test_pwr_cmd_master.sv
module test_pwr_cmd_master;

  localparam int HALF  = 2;
  localparam int MAXB  = 4;
  localparam int LEN_W = $clog2(MAXB + 1);
  localparam int BB    = 8 * MAXB;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             reqValid = 1'b0;
  logic             reqReady;
  logic             reqRead = 1'b0;
  logic [3:0]       reqAddr = '0;
  logic [7:0]       reqCmd = '0;
  logic [LEN_W-1:0] reqLen = '0;
  logic [BB-1:0]    reqData = '0;
  logic             sclk, sdaOut, sdaOe;
  logic             sdaIn = 1'b0;
  logic             done, rspAck, rspParErr;
  logic [BB-1:0]    rspData;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  pwr_cmd_master #(.HALF_DIV(HALF), .MAX_BYTES(MAXB)) i_pwr_cmd_master (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqRead(reqRead), .reqAddr(reqAddr), .reqCmd(reqCmd), .reqLen(reqLen),
    .reqData(reqData), .sclk(sclk), .sdaOut(sdaOut), .sdaOe(sdaOe),
    .sdaIn(sdaIn), .done(done), .rspAck(rspAck), .rspParErr(rspParErr),
    .rspData(rspData)
  );

  // Reference model: one entry per system clock of the sequence.
  logic [2:0] expPins[$];   // {sclk, sdaOe, sdaOut}
  logic       slvBit[$];    // level the far device puts on the line
  string      tagQ[$];

  task automatic chk(input bit ok, input string msg);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic addSlot(input logic pulse, input logic oe, input logic so,
                         input logic sb, input string tag);
    for (int h = 0; h < 2 * HALF; h++) begin
      expPins.push_back({pulse && (h < HALF), oe, so});
      slvBit.push_back(sb);
      tagQ.push_back(tag);
    end
  endtask

  task automatic runSeq(input logic [3:0] a, input logic [7:0] c, input bit rd,
                        input int len, input logic [BB-1:0] wdat,
                        input logic [BB-1:0] sdat, input logic sack,
                        input int badFrame, input string note);
    int eff;
    logic [11:0] cw;
    logic [BB-1:0] expData;
    bit expPerr;
    int S;
    eff = (len == 0) ? 1 : ((len > MAXB) ? MAXB : len);
    expPins.delete(); slvBit.delete(); tagQ.delete();
    addSlot(1'b0, 1'b1, 1'b1, 1'b0, "R2");
    addSlot(1'b0, 1'b1, 1'b0, 1'b1, "R2");
    cw = {a, c};
    for (int i = 11; i >= 0; i--) addSlot(1'b1, 1'b1, cw[i], ~cw[i], "R3/R4");
    addSlot(1'b1, 1'b1, ~^cw, ^cw, "R3/R4");
    expData = '0;
    expPerr = 1'b0;
    for (int b = 0; b < eff; b++) begin
      logic [7:0] by;
      logic par;
      by  = rd ? sdat[8*b +: 8] : wdat[8*b +: 8];
      par = ~^by;
      if (rd && b == badFrame) begin
        par = ~par;
        expPerr = 1'b1;
      end
      if (rd) expData[8*b +: 8] = by;
      for (int i = 7; i >= 0; i--)
        if (rd) addSlot(1'b1, 1'b0, 1'b0, by[i], "R7/R4");
        else    addSlot(1'b1, 1'b1, by[i], ~by[i], "R5/R4");
      if (rd) addSlot(1'b1, 1'b0, 1'b0, par, "R7/R8");
      else    addSlot(1'b1, 1'b1, par, ~par, "R5/R4");
    end
    addSlot(1'b1, 1'b0, 1'b0, sack, "R9");
    addSlot(1'b1, 1'b1, 1'b0, 1'b0, "R10");
    S = expPins.size();

    @(negedge clk);
    chk(reqReady === 1'b1, $sformatf("R11 %s ready before request act=%b exp=1", note, reqReady));
    reqValid = 1'b1; reqRead = rd; reqAddr = a; reqCmd = c;
    reqLen = LEN_W'(len); reqData = wdat;
    @(posedge clk);
    for (int j = 0; j <= S + 1; j++) begin
      logic [2:0] ep;
      bit eRdy, eDone;
      @(negedge clk);
      if (j == 0) begin
        // R12: scramble the request inputs once the request is taken.
        reqValid = 1'b0; reqRead = ~rd; reqAddr = ~a; reqCmd = ~c;
        reqLen = '0; reqData = ~wdat;
      end
      ep    = (j == 0 || j == S + 1) ? 3'b000 : expPins[j-1];
      eRdy  = (j >= S);
      eDone = (j == S);
      chk({sclk, sdaOe, sdaOut} === ep && reqReady === eRdy && done === eDone,
          $sformatf("%s %s R12 cycle %0d pins/ready/done act=%b%b%b/%b/%b exp=%b/%b/%b",
                    (j == 0 || j > S) ? "R1/R11" : tagQ[j-1], note, j,
                    sclk, sdaOe, sdaOut, reqReady, done, ep, eRdy, eDone));
      sdaIn = (j < S) ? slvBit[j] : 1'b0;
      if (j >= S) begin
        chk(rspData === expData, $sformatf("R7 R11 %s rspData act=%h exp=%h", note, rspData, expData));
        chk(rspAck === sack, $sformatf("R9 %s rspAck act=%b exp=%b", note, rspAck, sack));
        chk(rspParErr === expPerr, $sformatf("R8 %s rspParErr act=%b exp=%b", note, rspParErr, expPerr));
      end
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired, R11 sequence never completed act=hung exp=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sclk === 1'b0 && sdaOe === 1'b0 && sdaOut === 1'b0,
        $sformatf("R1 reset pins act=%b%b%b exp=000", sclk, sdaOe, sdaOut));
    chk(reqReady === 1'b1 && done === 1'b0,
        $sformatf("R1 reset ready/done act=%b/%b exp=1/0", reqReady, done));
    chk(rspData === '0 && rspAck === 1'b0 && rspParErr === 1'b0,
        $sformatf("R1 reset rsp act=%h/%b/%b exp=0/0/0", rspData, rspAck, rspParErr));
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    runSeq(4'hA, 8'h5C, 1'b0, 2, 32'h0000_C3A5, 32'h0, 1'b1, -1, "R5 write two");
    runSeq(4'h0, 8'h00, 1'b0, 1, 32'h0000_0000, 32'h0, 1'b0, -1, "R9 write nack zeros");
    runSeq(4'hF, 8'hFF, 1'b0, 4, 32'h8001_7EFF, 32'h0, 1'b1, -1, "R5 write four");
    runSeq(4'h5, 8'h1E, 1'b0, 0, 32'h0000_0096, 32'h0, 1'b1, -1, "R6 zero length");
    runSeq(4'h9, 8'hA0, 1'b0, 6, 32'h1234_5678, 32'h0, 1'b1, -1, "R6 over length");
    runSeq(4'h3, 8'h38, 1'b1, 3, 32'hFFFF_FFFF, 32'h00B7_4C01, 1'b1, -1, "R7 read three");
    runSeq(4'hC, 8'h3F, 1'b1, 2, 32'h0, 32'h0000_FF00, 1'b0, 1, "R8 read bad parity");
    runSeq(4'h6, 8'h2B, 1'b1, 0, 32'h0, 32'h0000_0055, 1'b1, 0, "R6 R8 read zero length");
    runSeq(4'h1, 8'hC7, 1'b1, 7, 32'h0, 32'hDEAD_BEEF, 1'b1, -1, "R6 R7 read over length");

    // R11: response held while idle
    repeat (5) @(negedge clk);
    chk(rspData === 32'hDEAD_BEEF && rspAck === 1'b1 && rspParErr === 1'b0,
        $sformatf("R11 response hold act=%h/%b/%b exp=deadbeef/1/0", rspData, rspAck, rspParErr));
    summary();
    $finish;
  end

endmodule